// File: doc/BRIEF.md
# DDR Read Data Edge Resynchronizer

This block sits between the strobe-timed capture stage of a DDR read path and the read FIFOs. It receives, for each data bit, a rise-phase stream and a fall-phase stream that are still timed by the data strobe. It moves both streams into the rising-edge domain of the system clock.

Each bit is registered twice, once on the rising edge and once on the falling edge of the system clock. Samples taken on the falling edge are registered again on a rising edge. A per-bit select, set by a calibration controller outside the block and held stable while reads run, chooses which of the two paths drives that bit. Offering both edges lets the calibration reach alignment with fewer input delay taps.

When any bit uses the falling path, the bits on the rising path receive one extra register. This keeps every word whole: all bits of a word leave on the same cycle. An optional pipeline stage, chosen by parameter, sits before the outputs. A valid flag travels with the data and takes the same latency.

Top module: `ddr_rd_resync`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every rank register. In the cycle after reset, `out_valid` is 0 and both `rise_out` and `fall_out` are all zeros.
- R2: When every bit of `edge_sel` is 0 (rising path), a word presented with `in_valid` high emerges with `out_valid` high 2 + PIPE_EN rising edges later. PIPE_EN is 1 by default.
- R3: When at least one bit of `edge_sel` is 1 (falling path), every word takes 3 + PIPE_EN rising edges to emerge.
- R4: The rise word and the fall word presented together always emerge together, unchanged, on the same output cycle.
- R5: With a mixed `edge_sel` (some bits 1, some 0), the output word equals the input word bit for bit. The bits on the rising path are delayed to match the bits on the falling path.
- R6: A cycle with `in_valid` low produces a cycle with `out_valid` low at the matching output slot, and `out_valid` is never high without a matching input word.
- R7: Words presented on consecutive cycles emerge on consecutive cycles, in the order they were presented.
- R8: A reset asserted while words are in flight discards them. None of those words produces `out_valid` after the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; both of its edges are used |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks a captured word pair on the inputs |
| rise_in | input | DATA_W | Rise-phase word from the capture stage |
| fall_in | input | DATA_W | Fall-phase word from the capture stage |
| edge_sel | input | DATA_W | Per-bit path select: 1 = falling-edge path, 0 = rising-edge path |
| rise_out | output | DATA_W | Resynchronized rise-phase word |
| fall_out | output | DATA_W | Resynchronized fall-phase word |
| out_valid | output | 1 | Marks a valid word pair on the outputs |

## Verification
On every cycle, the checker tests the reset clearing, the valid latency for both the all-rising and the any-falling configuration, and the relation between each output word and the input sampled that many cycles earlier. It also checks that a bubble at the input stays a bubble at the output. The bench scenarios are needed to show the following: that a mixed select still yields a coherent word, that back-to-back words keep their order with no gaps, and that words in flight vanish after a reset in the middle of a stream. These depend on sequences of select values and on resets that a single-window property cannot express.

// File: rtl/ddr_rs_pkg.sv
package ddr_rs_pkg;

  // Number of rising edges from input to output for a given configuration.
  function automatic int unsigned path_latency(input logic any_fall, input int unsigned pipe_en);
    int unsigned lat;
    lat = 2;
    if (any_fall) lat = lat + 1;
    if (pipe_en != 0) lat = lat + 1;
    return lat;
  endfunction

endpackage

// File: rtl/ddr_rs_lane.sv
// One data bit: rising and falling capture ranks plus the path multiplexer.
// Bit 0 of each pair register is the rise stream, bit 1 the fall stream.
module ddr_rs_lane (
  input  logic clk,
  input  logic rst,
  input  logic d_rise,
  input  logic d_fall,
  input  logic use_fall,
  input  logic any_fall,
  output logic pick_rise,
  output logic pick_fall
);

  logic [1:0] pos_r1;   // rising-edge capture
  logic [1:0] pos_r2;   // extra rank for word alignment
  logic [1:0] neg_r1;   // falling-edge capture
  logic [1:0] neg_r2;   // realigned onto the rising edge
  logic [1:0] neg_r3;   // alignment rank of the falling path
  logic [1:0] pick;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_r1 <= '0;
      pos_r2 <= '0;
      neg_r2 <= '0;
      neg_r3 <= '0;
    end else begin
      pos_r1 <= {d_fall, d_rise};
      pos_r2 <= pos_r1;
      neg_r2 <= neg_r1;
      neg_r3 <= neg_r2;
    end
  end

  always_ff @(negedge clk) begin
    if (rst) neg_r1 <= '0;
    else     neg_r1 <= {d_fall, d_rise};
  end

  always_comb begin
    if (use_fall)      pick = neg_r3;
    else if (any_fall) pick = pos_r2;
    else               pick = pos_r1;
  end

  assign pick_rise = pick[0];
  assign pick_fall = pick[1];

endmodule

// File: rtl/ddr_rs_vdelay.sv
// Delays the input valid flag to line up with the selected data path.
module ddr_rs_vdelay (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic any_fall,
  output logic aligned_valid
);

  logic [1:0] vsh;

  always_ff @(posedge clk) begin
    if (rst) vsh <= '0;
    else     vsh <= {vsh[0], in_valid};
  end

  assign aligned_valid = any_fall ? vsh[1] : vsh[0];

endmodule

// File: rtl/ddr_rs_outstage.sv
// Output register rank and the optional read pipeline stage.
module ddr_rs_outstage #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned PIPE_EN = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] d_rise,
  input  logic [DATA_W-1:0] d_fall,
  input  logic              d_valid,
  output logic [DATA_W-1:0] q_rise,
  output logic [DATA_W-1:0] q_fall,
  output logic              q_valid
);

  logic [DATA_W-1:0] o_rise, o_fall;
  logic              o_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_rise  <= '0;
      o_fall  <= '0;
      o_valid <= 1'b0;
    end else begin
      o_rise  <= d_rise;
      o_fall  <= d_fall;
      o_valid <= d_valid;
    end
  end

  generate
    if (PIPE_EN != 0) begin : g_pipe
      logic [DATA_W-1:0] p_rise, p_fall;
      logic              p_valid;
      always_ff @(posedge clk) begin
        if (rst) begin
          p_rise  <= '0;
          p_fall  <= '0;
          p_valid <= 1'b0;
        end else begin
          p_rise  <= o_rise;
          p_fall  <= o_fall;
          p_valid <= o_valid;
        end
      end
      assign q_rise  = p_rise;
      assign q_fall  = p_fall;
      assign q_valid = p_valid;
    end else begin : g_nopipe
      assign q_rise  = o_rise;
      assign q_fall  = o_fall;
      assign q_valid = o_valid;
    end
  endgenerate

endmodule

// File: rtl/ddr_rd_resync.sv
module ddr_rd_resync #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned PIPE_EN = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] rise_in,
  input  logic [DATA_W-1:0] fall_in,
  input  logic [DATA_W-1:0] edge_sel,
  output logic [DATA_W-1:0] rise_out,
  output logic [DATA_W-1:0] fall_out,
  output logic              out_valid
);

  // Named internal events for the checker.
  logic              any_fall;
  logic [DATA_W-1:0] mux_rise;
  logic [DATA_W-1:0] mux_fall;
  logic              core_valid;

  assign any_fall = |edge_sel;

  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_lane
      ddr_rs_lane u_lane (
        .clk      (clk),
        .rst      (rst),
        .d_rise   (rise_in[b]),
        .d_fall   (fall_in[b]),
        .use_fall (edge_sel[b]),
        .any_fall (any_fall),
        .pick_rise(mux_rise[b]),
        .pick_fall(mux_fall[b])
      );
    end
  endgenerate

  ddr_rs_vdelay u_vdelay (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .any_fall     (any_fall),
    .aligned_valid(core_valid)
  );

  ddr_rs_outstage #(.DATA_W(DATA_W), .PIPE_EN(PIPE_EN)) u_out (
    .clk    (clk),
    .rst    (rst),
    .d_rise (mux_rise),
    .d_fall (mux_fall),
    .d_valid(core_valid),
    .q_rise (rise_out),
    .q_fall (fall_out),
    .q_valid(out_valid)
  );

endmodule

// File: rtl/ddr_rd_resync_chk.sv
module ddr_rd_resync_chk #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned PIPE_EN = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] rise_in,
  input logic [DATA_W-1:0] fall_in,
  input logic              any_fall,
  input logic [DATA_W-1:0] rise_out,
  input logic [DATA_W-1:0] fall_out,
  input logic              out_valid
);
  import ddr_rs_pkg::*;

  localparam int unsigned LAT_R = path_latency(1'b0, PIPE_EN);
  localparam int unsigned LAT_F = path_latency(1'b1, PIPE_EN);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && rise_out == '0 && fall_out == '0));

  // R2
  rise_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !any_fall) |-> ##LAT_R out_valid);

  // R3
  fall_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && any_fall) |-> ##LAT_F out_valid);

  // R4
  rise_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !any_fall) |-> (rise_out == $past(rise_in, LAT_R) && fall_out == $past(fall_in, LAT_R)));

  // R5
  fall_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && any_fall) |-> (rise_out == $past(rise_in, LAT_F) && fall_out == $past(fall_in, LAT_F)));

  // R6
  bubble_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !any_fall) |-> ##LAT_R !out_valid);

  // R6
  bubble_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && any_fall) |-> ##LAT_F !out_valid);

endmodule

bind ddr_rd_resync ddr_rd_resync_chk #(.DATA_W(DATA_W), .PIPE_EN(PIPE_EN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .rise_in  (rise_in),
  .fall_in  (fall_in),
  .any_fall (any_fall),
  .rise_out (rise_out),
  .fall_out (fall_out),
  .out_valid(out_valid)
);

// File: tb/tb_ddr_rd_resync.sv
`timescale 1ns/1ps
module tb_ddr_rd_resync;
  localparam int W    = 8;
  localparam int PIPE = 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] rise_in = '0;
  logic [W-1:0] fall_in = '0;
  logic [W-1:0] edge_sel = '0;
  logic [W-1:0] rise_out, fall_out;
  logic         out_valid;

  always #4 clk = ~clk;   // 125 MHz

  ddr_rd_resync #(.DATA_W(W), .PIPE_EN(PIPE)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .rise_in(rise_in),
    .fall_in(fall_in), .edge_sel(edge_sel), .rise_out(rise_out),
    .fall_out(fall_out), .out_valid(out_valid)
  );

  typedef struct {
    int           due;
    logic [W-1:0] r;
    logic [W-1:0] f;
    string        tag;
  } item_t;

  item_t sb[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Expected latency restated from the requirements.
  function automatic int exp_lat(input logic [W-1:0] sel);
    return (sel == '0) ? 2 + PIPE : 3 + PIPE;
  endfunction

  task automatic send(input logic [W-1:0] r, input logic [W-1:0] f, input bit v, input string tag);
    item_t it;
    @(posedge clk); #1;
    rise_in  = r;
    fall_in  = f;
    in_valid = v;
    if (v) begin
      it.due = cyc + exp_lat(edge_sel);
      it.r = r; it.f = f; it.tag = tag;
      sb.push_back(it);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send('0, '0, 1'b0, "R6");
  endtask

  task automatic set_sel(input logic [W-1:0] s);
    idle(6);
    @(posedge clk); #1;
    edge_sel = s;
  endtask

  // Monitor: compare outputs with the scoreboard head.
  always @(posedge clk) begin
    #2;
    if (!rst && sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (!out_valid) begin
        errors++;
        $display("FAIL %s out_valid missing at cycle %0d: actual=0 expected=1", it.tag, cyc);
      end
      checks++;
      if (rise_out !== it.r || fall_out !== it.f) begin
        errors++;
        $display("FAIL R4 (stream %s) data: actual=%h/%h expected=%h/%h",
                 it.tag, rise_out, fall_out, it.r, it.f);
      end
    end else if (out_valid === 1'b1) begin
      checks++;
      errors++;
      $display("FAIL R6 spurious out_valid at cycle %0d: actual=1 expected=0", cyc);
    end
  end

  task automatic expect_quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #3;
      checks++;
      if (out_valid !== 1'b0) begin
        errors++;
        $display("FAIL %s out_valid after reset: actual=%b expected=0", tag, out_valid);
      end
    end
  endtask

  initial begin
    #(8 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #3;
    checks++;
    if (out_valid !== 1'b0 || rise_out !== '0 || fall_out !== '0) begin
      errors++;
      $display("FAIL R1 reset state: actual=%b/%h/%h expected=0/00/00", out_valid, rise_out, fall_out);
    end
    @(posedge clk); #1; rst = 1'b0;

    // R2: all bits on the rising path
    edge_sel = '0;
    send(8'h3C, 8'hC3, 1, "R2");
    idle(4);
    // R7: back-to-back stream on rising path
    for (int i = 0; i < 6; i++) send(8'(i * 17 + 1), 8'(8'hF0 - i), 1, "R7");
    // R6: bubbles interleaved
    send(8'hAA, 8'h55, 1, "R6");
    send(8'h00, 8'h00, 0, "R6");
    send(8'h11, 8'h22, 1, "R6");
    send(8'h00, 8'h00, 0, "R6");

    // R3: all bits on the falling path
    set_sel(8'hFF);
    send(8'h5A, 8'hA5, 1, "R3");
    idle(4);
    for (int i = 0; i < 5; i++) send(8'(8'h80 >> i), 8'(1 << i), 1, "R7");

    // R5: mixed select keeps the word coherent
    set_sel(8'h01);
    send(8'hFF, 8'h00, 1, "R5");
    send(8'h81, 8'h7E, 1, "R5");
    set_sel(8'hA5);
    for (int i = 0; i < 4; i++) send(8'(8'h96 ^ i), 8'(8'h69 + i), 1, "R5");
    send(8'h00, 8'h00, 0, "R6");
    send(8'hC0, 8'h03, 1, "R5");

    // R8: reset with words in flight
    set_sel(8'h0F);
    send(8'h12, 8'h34, 1, "R8");
    send(8'h56, 8'h78, 1, "R8");
    send(8'h9A, 8'hBC, 1, "R8");
    @(posedge clk); #1;
    in_valid = 1'b0;
    rst = 1'b1;
    while (sb.size() > 0 && sb[$].due > cyc) void'(sb.pop_back());
    @(posedge clk); #1;
    rst = 1'b0;
    expect_quiet(6, "R8");

    // R2 again after reset, rising path
    set_sel('0);
    send(8'hE7, 8'h18, 1, "R2");
    idle(8);

    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R7 words not delivered: actual=%0d expected=0", sb.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule